// File: doc/BRIEF.md
# Revertive Priority Clock Input Selector

This block chooses which of two reference clock paths drives a downstream clock tree. The first path is always the first reference pin. The second path has a front-end multiplexer. In free-run mode that multiplexer replaces the second reference pin with the local oscillator clock. The replacement happens ahead of every monitor and every decision, so the whole block treats the oscillator as the second input. This gives automatic failover from the first reference to the oscillator, and a return to the first reference when it comes back.

Every path has an activity monitor. Each monitor counts the edges of its path clock over a fixed window timed by the oscillator, which always runs. A controller in the oscillator domain picks the path from these validity flags and from the synchronized configuration pins. It can pick automatically, by priority, with or without reversion, or it can follow a manual select pin. A glitch-free handshake multiplexer then moves the output clock to the chosen path.

Top module: `ref_clk_selector`

## Requirements
- R1: With `free_run` high, the second path carries the oscillator clock: `act2` is 1 even when `ref2_clk` is stopped, and selecting path 1 outputs the oscillator clock.
- R2: With `free_run` low, `act2` follows the activity of the `ref2_clk` pin.
- R3: A path whose clock shows fewer than MIN_EDGES rising edges in one window has its activity flag cleared by the end of the next window. The flag changes only at window ends.
- R4: A cleared activity flag is set again only after GOOD_WINS consecutive windows that each see at least MIN_EDGES edges.
- R5: In automatic mode (`autosel_en`=1) with `pri_sel`=0 and both paths valid, `sel_src` is 0, which means the first reference.
- R6: In automatic mode, when the selected path is invalid and the other path is valid, `sel_src` moves to the other path (0 = first reference, 1 = second path).
- R7: In automatic mode with `revert_en`=1, the selector returns to the preferred path as soon as that path is valid.
- R8: In automatic mode with `revert_en`=0, the selector stays on a valid current path even when the preferred path becomes valid again.
- R9: Out of reset `sel_src`=0, `act1`=`act2`=0 and `no_valid`=1. When both paths are invalid, `no_valid` is 1 and `sel_src` holds its value.
- R10: With `autosel_en`=0, `sel_src` follows `man_sel` and never switches on its own, even if the chosen path is dead.
- R11: `clk_out` carries the clock of the selected path and is low when that path is stopped. No high or low pulse on it is shorter than the shortest half period of the input clocks.
- R12: With `pri_sel`=1, the second path becomes the preferred one for R5 through R7.
- R13: A change on `man_sel` in manual mode shows on `sel_src` on the third oscillator rising edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local oscillator clock; clocks all monitoring and control |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref1_clk | input | 1 | First reference clock |
| ref2_clk | input | 1 | Second reference clock, replaced in free-run mode |
| free_run | input | 1 | 1 = second path takes the oscillator clock (static setting) |
| pri_sel | input | 1 | Preferred path: 0 = first reference, 1 = second path |
| revert_en | input | 1 | 1 = return to the preferred path when it recovers |
| autosel_en | input | 1 | 1 = automatic selection, 0 = manual via man_sel |
| man_sel | input | 1 | Manual path choice: 0 = first, 1 = second |
| sel_src | output | 1 | Selected path: 0 = first, 1 = second |
| act1 | output | 1 | First path activity valid |
| act2 | output | 1 | Second path activity valid (oscillator in free-run mode) |
| no_valid | output | 1 | Both paths invalid |
| clk_out | output | 1 | Glitch-free selected clock |

## Verification
The bench builds the block with WIN_CYC=32, MIN_EDGES=2 and GOOD_WINS=4. With these values a window is 128 ns, a loss is seen within about 260 ns and a recovery within about 650 ns. That short timing lets one run cover every failover, reversion, free-run swap and manual transition. The reference periods (20 ns and 28 ns) give 6 and 4 edges per window, so both sit clearly above the MIN_EDGES threshold. Those periods also differ from each other and from the 4 ns oscillator, so counting edges on `clk_out` shows which source is driving it.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;
  localparam int NUM_PATHS = 2;

  typedef struct packed {
    logic prefer_b;
    logic revert;
    logic autosel;
    logic man_b;
  } sel_ctl_t;
endpackage

// File: rtl/refsel_sync.sv
`timescale 1ns/1ps
module refsel_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/refsel_mon.sv
`timescale 1ns/1ps
module refsel_mon #(
  parameter int WIN_CYC     = 256,
  parameter int MIN_EDGES   = 2,
  parameter int GOOD_WINS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic osc_clk,
  input  logic rst_n,
  output logic ok_o
);
  localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam int RW = (GOOD_WINS > 1) ? $clog2(GOOD_WINS) : 1;

  // toggle in the monitored domain, one flip per rising edge
  logic tog_q;
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  logic tog_s, tog_d;
  refsel_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tog_sync (
    .clk(osc_clk), .rst_n(rst_n), .d(tog_q), .q(tog_s)
  );

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) tog_d <= 1'b0;
    else        tog_d <= tog_s;
  end

  logic seen_edge;
  assign seen_edge = tog_s ^ tog_d;

  logic [CW-1:0] wcnt_q;
  logic [EW-1:0] ecnt_q;
  logic [RW-1:0] run_q;
  logic          ok_q;
  logic          win_end, win_good;

  assign win_end  = (wcnt_q == CW'(WIN_CYC - 1));
  assign win_good = (int'(ecnt_q) + int'(seen_edge)) >= MIN_EDGES;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
      run_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      wcnt_q <= win_end ? '0 : wcnt_q + 1'b1;
      if (win_end)
        ecnt_q <= '0;
      else if (seen_edge && ecnt_q != EW'(MIN_EDGES))
        ecnt_q <= ecnt_q + 1'b1;
      if (win_end) begin
        if (!win_good) begin
          ok_q  <= 1'b0;
          run_q <= '0;
        end else if (run_q == RW'(GOOD_WINS - 1)) begin
          ok_q  <= 1'b1;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assign ok_o = ok_q;

  AST_FLAG_AT_WINDOW: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !win_end |=> $stable(ok_q)); // R3

  AST_RECOVER_AFTER_RUN: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(ok_q) |-> ($past(run_q) == RW'(GOOD_WINS - 1))); // R4
endmodule

// File: rtl/refsel_ctrl.sv
`timescale 1ns/1ps
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 osc_clk,
  input  logic                 rst_n,
  input  sel_ctl_t             ctl_async,
  input  logic [NUM_PATHS-1:0] path_ok,
  output logic                 sel_o,
  output logic                 no_valid_o
);
  localparam int CTLW = $bits(sel_ctl_t);

  logic [CTLW-1:0] ctl_vec;
  sel_ctl_t        ctl_s;

  refsel_sync #(.W(CTLW), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(osc_clk), .rst_n(rst_n), .d(ctl_async), .q(ctl_vec)
  );
  assign ctl_s = sel_ctl_t'(ctl_vec);

  logic sel_q, sel_d, nov_q;
  logic pref, alt, cur_ok, oth_ok;

  assign pref   = ctl_s.prefer_b;
  assign alt    = ~ctl_s.prefer_b;
  assign cur_ok = path_ok[sel_q];
  assign oth_ok = path_ok[~sel_q];

  always_comb begin
    sel_d = sel_q;
    if (!ctl_s.autosel)
      sel_d = ctl_s.man_b;
    else if (!cur_ok && oth_ok)
      sel_d = ~sel_q;
    else if (cur_ok && ctl_s.revert && (sel_q == alt) && path_ok[pref])
      sel_d = pref;
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      nov_q <= 1'b1;
    end else begin
      sel_q <= sel_d;
      nov_q <= ~|path_ok;
    end
  end

  assign sel_o      = sel_q;
  assign no_valid_o = nov_q;

  AST_FAILOVER: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (ctl_s.autosel && !path_ok[sel_q] && path_ok[~sel_q]) |=> (sel_q != $past(sel_q))); // R6

  AST_PREFER_RETURN: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (ctl_s.autosel && ctl_s.revert && path_ok[ctl_s.prefer_b]) |=> (sel_q == $past(ctl_s.prefer_b))); // R7

  AST_NO_REVERT: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (ctl_s.autosel && !ctl_s.revert && path_ok[sel_q]) |=> $stable(sel_q)); // R8

  AST_HOLD_NONE: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (ctl_s.autosel && path_ok == '0) |=> $stable(sel_q)); // R9

  AST_MANUAL: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !ctl_s.autosel |=> (sel_q == $past(ctl_s.man_b))); // R10
endmodule

// File: rtl/refsel_gfmux.sv
`timescale 1ns/1ps
module refsel_gfmux
  import refsel_pkg::*;
(
  input  logic                 osc_clk,
  input  logic                 rst_n,
  input  logic [NUM_PATHS-1:0] clk_i,
  input  logic [NUM_PATHS-1:0] ok_i,
  input  logic                 sel_i,
  output logic                 clk_o
);
  logic [NUM_PATHS-1:0] en_all;

  for (genvar i = 0; i < NUM_PATHS; i++) begin : g_lane
    logic req, stg_q, en_q, lane_rst_n, kill;
    // a dead, unselected path cannot clock its own enable low: clear it
    assign kill       = ~ok_i[i] & (sel_i != 1'(i));
    assign lane_rst_n = rst_n & ~kill;
    assign req        = (sel_i == 1'(i)) & ~en_all[NUM_PATHS-1-i];

    always_ff @(posedge clk_i[i] or negedge lane_rst_n) begin
      if (!lane_rst_n) stg_q <= 1'b0;
      else             stg_q <= req;
    end

    always_ff @(negedge clk_i[i] or negedge lane_rst_n) begin
      if (!lane_rst_n) en_q <= 1'b0;
      else             en_q <= stg_q;
    end

    assign en_all[i] = en_q;
  end

  assign clk_o = |(clk_i & en_all);

  AST_ONE_LANE: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $onehot0(en_all)); // R11
endmodule

// File: rtl/ref_clk_selector.sv
`timescale 1ns/1ps
module ref_clk_selector
  import refsel_pkg::*;
#(
  parameter int WIN_CYC     = 256,
  parameter int MIN_EDGES   = 2,
  parameter int GOOD_WINS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic ref1_clk,
  input  logic ref2_clk,
  input  logic free_run,
  input  logic pri_sel,
  input  logic revert_en,
  input  logic autosel_en,
  input  logic man_sel,
  output logic sel_src,
  output logic act1,
  output logic act2,
  output logic no_valid,
  output logic clk_out
);
  logic [NUM_PATHS-1:0] path_clk, path_ok;
  sel_ctl_t             ctl;
  logic                 sel;

  // free-run swap sits ahead of monitors and selection
  assign path_clk[0] = ref1_clk;
  assign path_clk[1] = free_run ? osc_clk : ref2_clk;

  for (genvar i = 0; i < NUM_PATHS; i++) begin : g_mon
    refsel_mon #(
      .WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES),
      .GOOD_WINS(GOOD_WINS), .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
      .mon_clk(path_clk[i]), .osc_clk(osc_clk), .rst_n(rst_n), .ok_o(path_ok[i])
    );
  end

  assign ctl.prefer_b = pri_sel;
  assign ctl.revert   = revert_en;
  assign ctl.autosel  = autosel_en;
  assign ctl.man_b    = man_sel;

  refsel_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .osc_clk(osc_clk), .rst_n(rst_n), .ctl_async(ctl),
    .path_ok(path_ok), .sel_o(sel), .no_valid_o(no_valid)
  );

  refsel_gfmux u_mux (
    .osc_clk(osc_clk), .rst_n(rst_n), .clk_i(path_clk),
    .ok_i(path_ok), .sel_i(sel), .clk_o(clk_out)
  );

  assign sel_src = sel;
  assign act1    = path_ok[0];
  assign act2    = path_ok[1];
endmodule

// File: tb/sim_ref_clk_selector.sv
`timescale 1ns/1ps
module sim_ref_clk_selector;
  logic osc_clk = 1'b0, raw1 = 1'b0, raw2 = 1'b0;
  logic rst_n = 1'b0;
  logic r1_on = 1'b1, r2_on = 1'b1, g1 = 1'b0, g2 = 1'b0;
  logic free_run = 1'b0, pri_sel = 1'b0, revert_en = 1'b1, autosel_en = 1'b1, man_sel = 1'b0;
  logic sel_src, act1, act2, no_valid, clk_out;
  logic ref1_clk, ref2_clk;

  int errors = 0, checks = 0, n_edges = 0;
  bit done = 1'b0;
  realtime t_rise = -1.0, t_fall = -1.0, min_hi = 1.0e9, min_lo = 1.0e9;

  always #2 osc_clk = ~osc_clk;                 // 250 MHz
  initial begin #1; forever #10 raw1 = ~raw1; end
  initial begin #3; forever #14 raw2 = ~raw2; end
  always @(negedge raw1) g1 <= r1_on;           // stop clocks while low
  always @(negedge raw2) g2 <= r2_on;
  assign ref1_clk = raw1 & g1;
  assign ref2_clk = raw2 & g2;

  always @(posedge clk_out) begin
    n_edges++;
    if (t_fall >= 0.0 && ($realtime - t_fall) < min_lo) min_lo = $realtime - t_fall;
    t_rise = $realtime;
  end
  always @(negedge clk_out) begin
    if (t_rise >= 0.0 && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
    t_fall = $realtime;
  end

  ref_clk_selector #(.WIN_CYC(32), .MIN_EDGES(2), .GOOD_WINS(4), .SYNC_STAGES(2)) u0 (
    .osc_clk(osc_clk), .rst_n(rst_n), .ref1_clk(ref1_clk), .ref2_clk(ref2_clk),
    .free_run(free_run), .pri_sel(pri_sel), .revert_en(revert_en),
    .autosel_en(autosel_en), .man_sel(man_sel), .sel_src(sel_src),
    .act1(act1), .act2(act2), .no_valid(no_valid), .clk_out(clk_out)
  );

  // {free_run,pri_sel,revert,autosel,man,r1_on,r2_on, sel,act1,act2,nov, clk class}
  // clk class: 0 first ref, 1 second ref, 2 oscillator, 3 stopped
  localparam logic [12:0] VEC [0:19] = '{
    13'b0011011_0110_00, 13'b0011001_1010_01, 13'b0011011_0110_00,
    13'b1011010_0110_00, 13'b1011000_1010_10, 13'b1011010_0110_00,
    13'b1001010_0110_00, 13'b1001000_1010_10, 13'b1001010_1110_10,
    13'b1011010_0110_00, 13'b0011011_0110_00, 13'b0011010_0100_00,
    13'b0011000_0001_11, 13'b0011001_1010_01, 13'b0010001_0010_11,
    13'b0010101_1010_01, 13'b0010011_0110_00, 13'b0111011_1110_01,
    13'b0111010_0100_00, 13'b0111011_1110_01
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R5";   1: return "R6";   2: return "R7";   3: return "R1";
      4: return "R6";   5: return "R7";   6: return "R8";   7: return "R6";
      8: return "R8";   9: return "R7";  10: return "R2";  11: return "R2";
      12: return "R9"; 13: return "R6";  14: return "R10"; 15: return "R10";
      16: return "R10"; default: return "R12";
    endcase
  endfunction

  function automatic int clk_class(int n);
    if (n == 0) return 3;
    if (n >= 250) return 2;
    if (n >= 50 && n <= 62) return 0;
    if (n >= 35 && n <= 45) return 1;
    return 4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int idx, input logic [12:0] v);
    int n0;
    @(negedge osc_clk);
    {free_run, pri_sel, revert_en, autosel_en, man_sel, r1_on, r2_on} = v[12:6];
    #1500;
    n0 = n_edges;
    #1120;
    chk({vtag(idx), " vec sel"}, int'(sel_src), int'(v[5]));
    chk({vtag(idx), " vec act1"}, int'(act1), int'(v[4]));
    chk({vtag(idx), " vec act2"}, int'(act2), int'(v[3]));
    chk({vtag(idx), " vec no_valid"}, int'(no_valid), int'(v[2]));
    chk({"R11 clk source, ", vtag(idx)}, clk_class(n_edges - n0), int'(v[1:0]));
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100;
    @(negedge osc_clk);
    rst_n = 1'b1;
    @(negedge osc_clk);
    // reset state, R9
    chk("R9 reset sel", int'(sel_src), 0);
    chk("R9 reset act1", int'(act1), 0);
    chk("R9 reset act2", int'(act2), 0);
    chk("R9 reset no_valid", int'(no_valid), 1);

    for (int i = 0; i < 20; i++) run_vec(i, VEC[i]);

    // R3 loss detection and R4 recovery hysteresis on the first path
    @(negedge osc_clk);
    r1_on = 1'b0;
    #400;
    chk("R3 loss act1", int'(act1), 0);
    #1000;
    @(negedge osc_clk);
    r1_on = 1'b1;
    #320;
    chk("R4 early act1", int'(act1), 0);
    #560;
    chk("R4 late act1", int'(act1), 1);

    // R13 manual select latency
    @(negedge osc_clk);
    autosel_en = 1'b0; man_sel = 1'b0;
    #200;
    @(negedge osc_clk);
    chk("R13 manual base", int'(sel_src), 0);
    man_sel = 1'b1;
    repeat (2) @(posedge osc_clk);
    @(negedge osc_clk);
    chk("R13 before third edge", int'(sel_src), 0);
    @(posedge osc_clk);
    @(negedge osc_clk);
    chk("R13 at third edge", int'(sel_src), 1);
    #300;

    // R11 no runt pulses over the whole run
    chk("R11 min high pulse ok", int'(min_hi >= 1.9), 1);
    chk("R11 min low pulse ok", int'(min_lo >= 1.9), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule